// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Lock and Hand-over

This block decides which of up to seven masters owns a shared system bus. Every master drives an active-high request and an active-high lock, and receives an active-high grant. The grant vector is held in a register that is updated on the falling edge of the bus clock. At each update, the lowest-indexed requesting master wins. When nobody requests, master 0 gets the bus as the default master. While reset is asserted, master 0 is the only master granted.

A master that owns the bus and asserts its lock keeps ownership, whatever other requests arrive, until it drops the lock. A build-time bit vector can enable a one-cycle hand-over for each master. When ownership leaves a master whose bit is set, the grant vector is all zeros for one falling-edge period. The next owner is then chosen from the requests present at the end of that gap.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt` equals one-hot master 0 (bit 0 set, all other bits clear), whatever `req` and `lock` are.
- R2: At each falling edge where the owner is not locked and no hand-over applies, `gnt` selects the lowest-indexed asserted bit of `req`. Bit 0 has the highest priority.
- R3: When `req` is all zeros at an arbitration edge and the owner is not locked, `gnt` selects master 0.
- R4: `gnt` never has more than one bit set. It is all zeros only during a hand-over gap.
- R5: `gnt` changes only at a falling clock edge. A change of `req` or `lock` between falling edges leaves `gnt` unchanged until the next falling edge.
- R6: If the current owner's `lock` bit is high at a falling edge, `gnt` keeps its value, even when a higher-priority request or no request at all is present.
- R7: `lock` bits of masters that do not own the bus have no effect on `gnt`. This also applies during a hand-over gap.
- R8: When ownership moves away from master i and bit i of `HANDOVER_EN` is set, `gnt` is all zeros for exactly one falling-edge period. The next owner is chosen from `req` at the falling edge that ends the gap.
- R9: When ownership moves away from master i and bit i of `HANDOVER_EN` is clear, `gnt` moves straight to the new owner at the same falling edge.
- R10: A hand-over gap always ends at the next falling edge with exactly one grant bit set.
- R11: After `rst_n` rises, the first falling edge makes an ordinary arbitration decision from the current `req`, with master 0 as the prior owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock. The grant register updates on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. It forces the grant to master 0. |
| req | input | N_MASTERS | Request per master, active high. Bit 0 has the highest priority. |
| lock | input | N_MASTERS | Locked-transfer flag per master, active high. Only the owner's bit has an effect. |
| gnt | output | N_MASTERS | Registered grant vector: one-hot, or all zeros during a hand-over gap. |

## Verification
Two functions can fall on the same falling edge. The first case is a lock release by the owner together with a higher-priority request. The second is the end of a hand-over gap where the requests have changed since the gap began, so the gap decision must use the new requests and not the ones that started it. The bench drives both cases deliberately, with lock bits set on non-owners at the same time. A behavioural model then judges every edge and checks that the grant went to the master the requirements name.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Arbiter phase: a master owns the bus, or the bus is in a hand-over gap.
  typedef enum logic {
    PH_OWNED = 1'b0,
    PH_GAP   = 1'b1
  } arb_phase_e;

  localparam int unsigned ARB_MIN_MASTERS = 2;
  localparam int unsigned ARB_MAX_MASTERS = 7;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N_MASTERS = 6
) (
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] win_oh
);
  localparam logic [N_MASTERS-1:0] DFLT_OH = N_MASTERS'(1);

  logic [N_MASTERS-1:0] pick;
  logic                 any_req;

  // Each bit wins when it is set and nothing below it is set.
  for (genvar i = 0; i < N_MASTERS; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign pick[i] = req[i];
    end else begin : g_rest
      assign pick[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any_req = |req;
  assign win_oh  = any_req ? pick : DFLT_OH;

endmodule

// File: rtl/arb_owner_info.sv
module arb_owner_info #(
  parameter int unsigned          N_MASTERS   = 6,
  parameter logic [N_MASTERS-1:0] HANDOVER_EN = N_MASTERS'(6'b001010)
) (
  input  logic [N_MASTERS-1:0] gnt_q,
  input  logic [N_MASTERS-1:0] lock,
  output logic                 owner_locked,
  output logic                 owner_gap_en
);
  logic [N_MASTERS-1:0] lock_hit;
  logic [N_MASTERS-1:0] gap_hit;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_own
    assign lock_hit[i] = gnt_q[i] & lock[i];
    assign gap_hit[i]  = gnt_q[i] & HANDOVER_EN[i];
  end

  assign owner_locked = |lock_hit;
  assign owner_gap_en = |gap_hit;

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
  import arb_pkg::*;
#(
  parameter int unsigned N_MASTERS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] win_oh,
  input  logic                 owner_locked,
  input  logic                 owner_gap_en,
  output logic [N_MASTERS-1:0] gnt_q
);
  localparam logic [N_MASTERS-1:0] DFLT_OH = N_MASTERS'(1);

  arb_phase_e           phase_q, phase_d;
  logic [N_MASTERS-1:0] gnt_d;
  logic                 upd_en;

  // Next-state decision.
  always_comb begin
    gnt_d   = gnt_q;
    phase_d = phase_q;
    if (phase_q == PH_GAP) begin
      gnt_d   = win_oh;
      phase_d = PH_OWNED;
    end else if (!owner_locked && (win_oh != gnt_q)) begin
      if (owner_gap_en) begin
        gnt_d   = '0;
        phase_d = PH_GAP;
      end else begin
        gnt_d   = win_oh;
      end
    end
  end

  assign upd_en = (gnt_d != gnt_q) || (phase_d != phase_q);

  // Grant register, falling-edge clocked, with an explicit enable.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= DFLT_OH;
      phase_q <= PH_OWNED;
    end else if (upd_en) begin
      gnt_q   <= gnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int unsigned          N_MASTERS   = 6,
  parameter logic [N_MASTERS-1:0] HANDOVER_EN = N_MASTERS'(6'b001010)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] lock,
  output logic [N_MASTERS-1:0] gnt
);
  logic [N_MASTERS-1:0] win_oh;
  logic [N_MASTERS-1:0] gnt_q;
  logic                 owner_locked;
  logic                 owner_gap_en;

  arb_prio_pick #(
    .N_MASTERS (N_MASTERS)
  ) u_pick (
    .req    (req),
    .win_oh (win_oh)
  );

  arb_owner_info #(
    .N_MASTERS   (N_MASTERS),
    .HANDOVER_EN (HANDOVER_EN)
  ) u_owner (
    .gnt_q        (gnt_q),
    .lock         (lock),
    .owner_locked (owner_locked),
    .owner_gap_en (owner_gap_en)
  );

  arb_grant_reg #(
    .N_MASTERS (N_MASTERS)
  ) u_greg (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_oh       (win_oh),
    .owner_locked (owner_locked),
    .owner_gap_en (owner_gap_en),
    .gnt_q        (gnt_q)
  );

  assign gnt = gnt_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned          N_MASTERS   = 6,
  parameter logic [N_MASTERS-1:0] HANDOVER_EN = N_MASTERS'(6'b001010)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] lock,
  input logic [N_MASTERS-1:0] gnt
);

  // R4
  gnt_onehot0_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R6
  lock_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && ((gnt & 0) == 0) && (($past(gnt) & $past(lock)) != '0))
    |-> (gnt == $past(gnt)));

  // R10
  gap_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (gnt != '0));

  // R8
  gap_source_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && (gnt == '0)) |-> (($past(gnt) & HANDOVER_EN) != '0));

  // R9
  direct_move_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && (($past(gnt) & ~HANDOVER_EN) != '0) && (gnt != $past(gnt)))
    |-> (gnt != '0));

  // R2
  winner_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && (gnt != $past(gnt)) && (gnt != '0) && !gnt[0])
    |-> (((gnt & $past(req)) != '0) && (($past(req) & (gnt - N_MASTERS'(1))) == '0)));

endmodule

bind prio_bus_arbiter arb_checker #(
  .N_MASTERS   (N_MASTERS),
  .HANDOVER_EN (HANDOVER_EN)
) u_arb_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .lock  (lock),
  .gnt   (gnt)
);

// File: tb/test_prio_bus_arbiter.sv
`timescale 1ns/100ps
module test_prio_bus_arbiter;
  localparam int unsigned          N  = 6;
  localparam logic [N-1:0]         HO = 6'b001010;
  localparam int                   WATCHDOG_CYC = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] lock;
  logic [N-1:0] gnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model state: owner index, -1 during a hand-over gap.
  int           own;
  logic [N-1:0] expv;

  always #2 clk = ~clk;

  prio_bus_arbiter #(
    .N_MASTERS   (N),
    .HANDOVER_EN (HO)
  ) i_prio_bus_arbiter (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .lock  (lock),
    .gnt   (gnt)
  );

  function automatic int lowest_req(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return 0;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] want, input string tag);
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, want);
    end
  endtask

  task automatic model_edge();
    int w;
    if (!rst_n) own = 0;
    else if (own < 0) own = lowest_req(req);
    else if (!lock[own]) begin
      w = lowest_req(req);
      if (w != own) own = HO[own] ? -1 : w;
    end
    expv = (own < 0) ? '0 : (N'(1) << own);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // One bus cycle: drive after the rising edge, judge after the falling edge.
  task automatic step(input logic rv, input logic [N-1:0] r, input logic [N-1:0] l,
                      input string tag);
    @(posedge clk);
    #0.5;
    rst_n = rv;
    req   = r;
    lock  = l;
    #0.5;
    if (rv) check(gnt, expv, "R5 (no change before falling edge)");
    @(negedge clk);
    model_edge();
    #1;
    check(gnt, expv, tag);
    n_chk++;
    if ($countones(gnt) > 1 || (gnt == '0 && own >= 0)) begin
      n_bad++;
      $display("FAIL R4: gnt=%b expected=%b", gnt, expv);
    end
  endtask

  initial begin
    #(WATCHDOG_CYC * 4);
    n_bad++;
    $display("FAIL watchdog: gnt=%b expected=%b", gnt, expv);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req   = '0;
    lock  = '0;
    own   = 0;
    expv  = N'(1);
    // R1: reset forces master 0 whatever the requests
    step(1'b0, 6'b111111, 6'b111111, "R1");
    step(1'b0, 6'b111110, 6'b000000, "R1");
    step(1'b0, 6'b100000, 6'b000000, "R1");
    // R11: first decision right after release
    step(1'b1, 6'b100000, 6'b000000, "R11");
    // R9: master 5 has no gap, direct move
    step(1'b1, 6'b110000, 6'b000000, "R9");
    step(1'b1, 6'b111110, 6'b000000, "R2");
    // R8: master 1 has a gap enabled
    step(1'b1, 6'b000000, 6'b000000, "R8");
    step(1'b1, 6'b000000, 6'b000000, "R3 after gap (R10)");
    step(1'b1, 6'b000000, 6'b000000, "R3");
    step(1'b1, 6'b100000, 6'b000000, "R2");
    // R6: owner locked against higher priority
    step(1'b1, 6'b000011, 6'b100000, "R6");
    step(1'b1, 6'b000011, 6'b100000, "R6");
    // lock release coinciding with higher-priority request
    step(1'b1, 6'b000110, 6'b000000, "R6 release");
    step(1'b1, 6'b000001, 6'b000010, "R6");
    // R7: non-owner locks ignored, gap from master 1
    step(1'b1, 6'b001000, 6'b011101, "R7/R8");
    step(1'b1, 6'b000100, 6'b111111, "R10 fresh requests, locks ignored");
    step(1'b1, 6'b001000, 6'b000000, "R9");
    step(1'b1, 6'b010000, 6'b000000, "R8");
    step(1'b1, 6'b100000, 6'b000000, "R10");
    step(1'b1, 6'b100000, 6'b011111, "R7");
    step(1'b1, 6'b000100, 6'b011011, "R7");
    step(1'b1, 6'b000000, 6'b000100, "R6 no request");
    step(1'b1, 6'b000000, 6'b000000, "R3");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      step(1'b1, N'($urandom), N'($urandom & $urandom & $urandom), "R2 mixed");
    end
    // reset again in mid-run
    step(1'b0, 6'b101010, 6'b000000, "R1");
    step(1'b1, 6'b000100, 6'b000000, "R11");
    finish_run();
  end

endmodule